// File: doc/BRIEF.md
# Beat-Period Counting Digitiser

This block converts the slow beat produced by two free-running oscillators of nearly equal period into period counts and raw random bits. The oscillator that runs the block (`clk`) samples the other oscillator (`osc_in`) with a single flop. Because the two periods differ only slightly, that sampled level toggles slowly and forms the beat signal. A saturating counter, also clocked by `clk`, measures the number of `clk` cycles between consecutive rising edges of the beat. The counts spread because of jitter in the two oscillators, so the least significant bit of each count serves as the raw random bit.

A controller state machine runs the counter. Its states are `ST_IDLE`, `ST_ARM` and `ST_COUNT`, and it has these transitions:

- `ST_IDLE` → `ST_ARM` when `en` rises.
- `ST_ARM` → `ST_COUNT` on the first rising beat edge.
- `ST_ARM` or `ST_COUNT` → `ST_IDLE` whenever `en` is low.

While the machine is in `ST_COUNT`, each rising beat edge does three things: it closes the current period, hands the count to the output stage and restarts the counter. The output stage presents each count to a consumer with a req/ack handshake. It holds the count until the consumer acknowledges it, and it discards any count that completes while an earlier one is still waiting.

Top module: `coso_beat_digitizer`

## Requirements
- R1: On every rising `clk` edge the block samples `osc_in` into the beat flop, and a rising beat edge is a 0-to-1 change between two consecutive samples.
- R2: Each reported `count` equals the number of `clk` cycles between two consecutive rising beat edges. A bench with jitter-free clocks expects T_osc/|T_osc − T_clk| ± 1.
- R3: The first rising beat edge after `en` rises only starts a measurement, so no partial period is ever reported.
- R4: When the counter reaches 2^CNT_W − 1 it holds that value until the beat period ends, and that value is reported. It never wraps.
- R5: A completed count is loaded into `count` on the same `clk` edge at which `req` rises.
- R6: While `req` is high and `ack` is low, `req` stays high and `count` stays stable. Any count that completes meanwhile is dropped.
- R7: If `ack` is high while `req` is high, `req` goes low on the next `clk` edge.
- R8: `rnd_bit` always equals bit 0 of `count`.
- R9: When `en` is low, the counter is cleared, the machine returns to `ST_IDLE` and `req` is low from the next `clk` edge on.
- R10: After reset, `req`, `count` and `rnd_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling oscillator; clocks all flops |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Active-high run enable |
| osc_in | input | 1 | Sampled oscillator |
| ack | input | 1 | Consumer acknowledge, synchronous to `clk` |
| req | output | 1 | Count valid and waiting for acknowledge |
| count | output | CNT_W | Last accepted beat-period count |
| rnd_bit | output | 1 | Raw random bit (bit 0 of `count`) |

## Verification
A level on `osc_in` reaches the beat flop at the next `clk` edge. The resulting rising edge loads `req` and `count` one edge later. An `ack` clears `req` at the following edge, and a low `en` forces `req` low at the following edge. The bench drives `ack` and `en` and samples every output on falling `clk` edges, so each check reads values that have settled half a cycle after the edge that produced them. Jitter-free oscillators make the expected period count exact apart from one cycle of phase quantisation. The bench restarts the sampled oscillator with an offset chosen so that its edges never coincide with a rising `clk` edge.

// File: rtl/coso_dig_pkg.sv
package coso_dig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } dig_state_t;

    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_START = 2'd1,
        CNT_STEP  = 2'd2
    } cnt_op_t;

endpackage

// File: rtl/coso_beat_sampler.sv
module coso_beat_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic beat,
    output logic beat_rise
);

    logic sample_q;
    logic hist_q;

    // sampling flop: the beat signal itself
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            hist_q   <= 1'b0;
        end else begin
            sample_q <= osc_in;
            hist_q   <= sample_q;
        end
    end

    assign beat      = sample_q;
    assign beat_rise = sample_q & ~hist_q;

endmodule

// File: rtl/coso_sat_counter.sv
module coso_sat_counter
    import coso_dig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_t          op,
    output logic [CNT_W-1:0] value
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            unique case (op)
                CNT_CLEAR: value <= '0;
                CNT_START: value <= CNT_ONE;
                CNT_STEP:  value <= (value == CNT_MAX) ? value : value + CNT_ONE;
                default:   value <= value;
            endcase
        end
    end

endmodule

// File: rtl/coso_handoff.sv
module coso_handoff #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             capture,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             ack,
    output logic             req,
    output logic [CNT_W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req  <= 1'b0;
            data <= '0;
        end else if (flush) begin
            req <= 1'b0;
        end else if (req) begin
            // pending: new captures are dropped
            if (ack) begin
                req <= 1'b0;
            end
        end else if (capture) begin
            data <= cnt_in;
            req  <= 1'b1;
        end
    end

endmodule

// File: rtl/coso_beat_digitizer.sv
module coso_beat_digitizer
    import coso_dig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             osc_in,
    input  logic             ack,
    output logic             req,
    output logic [CNT_W-1:0] count,
    output logic             rnd_bit
);

    dig_state_t       state_q;
    dig_state_t       state_d;
    cnt_op_t          cnt_op;
    logic             capture;
    logic             beat;
    logic             beat_rise;
    logic [CNT_W-1:0] cnt_q;

    coso_beat_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_in    (osc_in),
        .beat      (beat),
        .beat_rise (beat_rise)
    );

    coso_sat_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (cnt_op),
        .value (cnt_q)
    );

    coso_handoff #(.CNT_W(CNT_W)) u_handoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (~en),
        .capture (capture),
        .cnt_in  (cnt_q),
        .ack     (ack),
        .req     (req),
        .data    (count)
    );

    assign rnd_bit = count[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_ARM;
            ST_ARM: begin
                if (!en)            state_d = ST_IDLE;
                else if (beat_rise) state_d = ST_COUNT;
            end
            ST_COUNT: if (!en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs to counter and handoff
    always_comb begin
        cnt_op  = CNT_CLEAR;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: cnt_op = CNT_CLEAR;
            ST_ARM:  cnt_op = (en && beat_rise) ? CNT_START : CNT_CLEAR;
            ST_COUNT: begin
                if (!en) begin
                    cnt_op = CNT_CLEAR;
                end else if (beat_rise) begin
                    cnt_op  = CNT_START;
                    capture = 1'b1;
                end else begin
                    cnt_op = CNT_STEP;
                end
            end
            default: cnt_op = CNT_CLEAR;
        endcase
    end

endmodule

// File: rtl/coso_beat_digitizer_chk.sv
module coso_beat_digitizer_chk
    import coso_dig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ack,
    input logic             req,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cnt_val,
    input dig_state_t       state
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req); // R9

    AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && en) |=> (req && $stable(count))); // R6

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && en && cnt_val == CNT_MAX) |=> (cnt_val == CNT_MAX || cnt_val == CNT_ONE)); // R4

    AST_ARM_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !req) |=> !req); // R3

    AST_NONZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (count != '0)); // R2

endmodule

bind coso_beat_digitizer coso_beat_digitizer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ack     (ack),
    .req     (req),
    .count   (count),
    .cnt_val (cnt_q),
    .state   (state_q)
);

// File: tb/coso_beat_digitizer_tb.sv
`timescale 1ns/1ps
module coso_beat_digitizer_tb;

    localparam int CNT_W   = 8;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             osc_a = 1'b0;
    logic             ack = 1'b0;
    logic             req;
    logic [CNT_W-1:0] count;
    logic             rnd_bit;

    real half_a = 10.2;
    bit  gen_go = 1'b0;
    bit  hold_mon = 1'b0;
    int  exp_q[$];
    int  n_tests = 0;
    int  n_fail = 0;
    int  e_v;
    int  c0;

    coso_beat_digitizer #(.CNT_W(CNT_W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .osc_in  (osc_a),
        .ack     (ack),
        .req     (req),
        .count   (count),
        .rnd_bit (rnd_bit)
    );

    always #10 clk = ~clk; // 50 MHz sampling oscillator

    // sampled oscillator, restarted with a fixed offset on each phase
    initial begin
        forever begin
            wait (gen_go);
            osc_a = 1'b0;
            #1.31;
            while (gen_go) begin
                #(half_a);
                osc_a = ~osc_a;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit near(input int act, input int exp);
        if (exp == CNT_MAX) return act == exp;
        return (act - exp >= -1) && (act - exp <= 1);
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (req && !hold_mon && exp_q.size() > 0) begin
                e_v = exp_q.pop_front();
                check(near(int'(count), e_v), "R1 R2 R4 R5 period count", int'(count), e_v);
                check(rnd_bit == count[0], "R8 random bit", int'(rnd_bit), int'(count[0]));
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                check(req == 1'b0, "R7 ack release", int'(req), 0);
            end
        end
    end

    // driver: restart oscillator, push expected counts, wait for drain
    task automatic run_phase(input real period_ns, input int exp, input int n);
        en = 1'b0;
        gen_go = 1'b0;
        repeat (3) @(negedge clk);
        half_a = period_ns / 2.0;
        for (int i = 0; i < n; i++) exp_q.push_back(exp);
        gen_go = 1'b1;
        en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req == 1'b0, "R10 reset req", int'(req), 0);
        check(count == '0, "R10 reset count", int'(count), 0);
        check(rnd_bit == 1'b0, "R10 reset rnd_bit", int'(rnd_bit), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: first count after enable must be a full period
        run_phase(20.4, 51, 6);
        run_phase(20.8, 26, 6);
        // R4: beat period 401 cycles saturates
        run_phase(20.05, CNT_MAX, 2);

        // R6 drop while pending
        en = 1'b0;
        gen_go = 1'b0;
        hold_mon = 1'b1;
        repeat (3) @(negedge clk);
        half_a = 10.4;
        gen_go = 1'b1;
        en = 1'b1;
        while (!req) @(negedge clk);
        c0 = int'(count);
        check(near(c0, 26), "R5 first count with req", c0, 26);
        repeat (100) @(negedge clk);
        check(req == 1'b1, "R6 req held", int'(req), 1);
        check(int'(count) == c0, "R6 count held", int'(count), c0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(req == 1'b0, "R7 ack release", int'(req), 0);
        while (!req) @(negedge clk);
        check(near(int'(count), 26), "R6 fresh count after ack", int'(count), 26);

        // R9 enable low clears pending req
        en = 1'b0;
        @(negedge clk);
        check(req == 1'b0, "R9 req low when disabled", int'(req), 0);
        repeat (60) @(negedge clk);
        check(req == 1'b0, "R9 req stays low", int'(req), 0);
        hold_mon = 1'b0;

        // R3 again after re-enable
        run_phase(20.4, 51, 3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule